// File: doc/BRIEF.md
# Interrupt-Driven Transfer Controller

This block takes over simple service requests that would otherwise cost a full interrupt entry. It has eight channels, each with its own trigger input. When a trigger arrives on a live channel, the block takes one grant on a memory bus. With that grant it reads a byte or a word from the channel's source pointer and writes it to the channel's destination pointer. It then advances one pointer, or neither, and decrements the channel's transfer counter.

A channel that is switched off, or whose counter has run out, does not move data. Its trigger becomes a one-cycle interrupt request on that channel's line, so the normal service routine runs instead. Software sets each channel through a write-only configuration port. The port selects a channel and one of four registers: control, count, source pointer and destination pointer.

The bus side is a plain master with a request/grant pair. Read data returns in the cycle the read is granted.

Top module: `evt_xfer_ctrl`

## Requirements
- R1: After reset no bus request, done pulse or interrupt is raised, and every channel is switched off with a count of zero.
- R2: A trigger on a live channel raises a read beat (`bus_we_o`=0) at that channel's source pointer. The cycle after that read beat is granted, a write beat (`bus_we_o`=1) goes to the destination pointer and carries the data captured at the grant.
- R3: Control bit 2 selects word (1) or byte (0) moves; `bus_size_o` shows the same value. A byte move writes the low 8 read bits with the upper bits zero. The pointer step is 2 for words and 1 for bytes.
- R4: Control bits [1:0] select the mode: 00 off, 01 advance source, 10 advance destination, 11 advance neither. Configuration selector 0 writes control, 1 writes count, 2 writes source and 3 writes destination.
- R5: Each transfer decrements the counter by one, unless control bit 3 (continuous) is set. In continuous mode the count never changes and the channel stays live even at a count of zero.
- R6: A trigger on a channel that is off, or that has a count of zero without continuous mode, makes no bus access. Instead it pulses that channel's `irq_o` bit for one cycle, in the cycle after the trigger.
- R7: When several channels are pending, the lowest-numbered one is served first. Each grant moves exactly one item, and two write beats are never adjacent.
- R8: `done_o` pulses during each write beat, and `done_ch_o` then names the channel being served.
- R9: A read beat is held until `bus_gnt_i` is high. No write beat occurs without a granted read in the cycle before it.
- R10: Further triggers on a channel that is already pending are merged, so the channel still makes a single transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | NCH | Per-channel service trigger |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_ch_i | input | CHW | Channel being configured |
| cfg_sel_i | input | 2 | Register select: 0 control, 1 count, 2 source, 3 destination |
| cfg_wdata_i | input | AW | Configuration write data |
| bus_req_o | output | 1 | Bus request, high during both beats |
| bus_gnt_i | input | 1 | Bus grant, sampled on the read beat |
| bus_we_o | output | 1 | 0 read beat, 1 write beat |
| bus_size_o | output | 1 | 1 word, 0 byte |
| bus_addr_o | output | AW | Beat address |
| bus_wdata_o | output | DW | Write data |
| bus_rdata_i | input | DW | Read data, valid in the granted read beat |
| done_o | output | 1 | Transfer completion pulse |
| done_ch_o | output | CHW | Channel served by the current write beat |
| irq_o | output | NCH | Forwarded interrupt request pulses |

## Verification
The hardest situation to reach is several pending channels competing while grant is held low. A lower channel must then overtake a higher one that is already waiting, and repeated triggers must fold into one transfer. The bench withholds grant and fires three channels in one cycle. It fires one of them twice more, then releases grant and checks the order and number of write beats. It also drains a channel's counter to zero, so the fallback interrupt path is reached from real transfers rather than from a preset count.

// File: rtl/evx_pkg.sv
package evx_pkg;
  typedef enum logic [1:0] {
    MODE_OFF     = 2'b00,
    MODE_INC_SRC = 2'b01,
    MODE_INC_DST = 2'b10,
    MODE_FIXED   = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    CFG_CTRL  = 2'b00,
    CFG_COUNT = 2'b01,
    CFG_SRC   = 2'b10,
    CFG_DST   = 2'b11
  } cfg_sel_e;

  localparam int unsigned CTRL_WORD_BIT = 2;
  localparam int unsigned CTRL_CONT_BIT = 3;
endpackage

// File: rtl/evx_chan.sv
module evx_chan
  import evx_pkg::*;
#(
  parameter int unsigned AW = 24,
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          trig_i,
  input  logic          cfg_we_i,
  input  logic [1:0]    cfg_sel_i,
  input  logic [AW-1:0] cfg_wdata_i,
  input  logic          upd_i,
  output logic          pend_o,
  output logic          word_o,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic          irq_o
);
  mode_e         mode_q;
  logic          word_q, cont_q, pend_q, irq_q;
  logic [CW-1:0] cnt_q, cnt_eff;
  logic [AW-1:0] src_q, dst_q, step;
  logic          live;

  always_comb begin
    step    = word_q ? AW'(2) : AW'(1);
    // count as it will be after an update landing this cycle
    cnt_eff = (upd_i && !cont_q) ? cnt_q - 1'b1 : cnt_q;
    live    = (mode_q != MODE_OFF) && (cont_q || (cnt_eff != '0));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_OFF;
      word_q <= 1'b0;
      cont_q <= 1'b0;
      cnt_q  <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= trig_i & ~live;
      if (upd_i) begin
        pend_q <= 1'b0;
        if (mode_q == MODE_INC_SRC) src_q <= src_q + step;
        if (mode_q == MODE_INC_DST) dst_q <= dst_q + step;
        if (!cont_q) cnt_q <= cnt_q - 1'b1;
      end
      if (trig_i && live) pend_q <= 1'b1;
      if (cfg_we_i) begin
        unique case (cfg_sel_e'(cfg_sel_i))
          CFG_CTRL: begin
            mode_q <= mode_e'(cfg_wdata_i[1:0]);
            word_q <= cfg_wdata_i[CTRL_WORD_BIT];
            cont_q <= cfg_wdata_i[CTRL_CONT_BIT];
          end
          CFG_COUNT: cnt_q <= cfg_wdata_i[CW-1:0];
          CFG_SRC:   src_q <= cfg_wdata_i;
          CFG_DST:   dst_q <= cfg_wdata_i;
          default: ;
        endcase
      end
    end
  end

  assign pend_o = pend_q;
  assign word_o = word_q;
  assign src_o  = src_q;
  assign dst_o  = dst_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/evx_prio.sv
module evx_prio #(
  parameter int unsigned N  = 8,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/evx_seq.sv
module evx_seq #(
  parameter int unsigned NCH = 8,
  parameter int unsigned AW  = 24,
  parameter int unsigned DW  = 16,
  localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           any_i,
  input  logic [CHW-1:0] sel_i,
  input  logic [AW-1:0]  src_sel_i,
  input  logic           word_sel_i,
  input  logic [AW-1:0]  dst_cur_i,
  input  logic           word_cur_i,
  input  logic           gnt_i,
  input  logic [DW-1:0]  rdata_i,
  output logic           req_o,
  output logic           we_o,
  output logic           size_o,
  output logic [AW-1:0]  addr_o,
  output logic [DW-1:0]  wdata_o,
  output logic           wr_o,
  output logic [CHW-1:0] cur_o
);
  typedef enum logic {SQ_READ, SQ_WRITE} sq_e;
  sq_e            st_q;
  logic [CHW-1:0] cur_q;
  logic [DW-1:0]  data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SQ_READ;
      cur_q  <= '0;
      data_q <= '0;
    end else if (st_q == SQ_WRITE) begin
      st_q <= SQ_READ;
    end else if (any_i && gnt_i) begin
      st_q   <= SQ_WRITE;
      cur_q  <= sel_i;
      data_q <= word_sel_i ? rdata_i : DW'(rdata_i[7:0]);
    end
  end

  assign wr_o    = (st_q == SQ_WRITE);
  assign req_o   = wr_o | any_i;
  assign we_o    = wr_o;
  assign addr_o  = wr_o ? dst_cur_i : src_sel_i;
  assign size_o  = wr_o ? word_cur_i : word_sel_i;
  assign wdata_o = data_q;
  assign cur_o   = cur_q;
endmodule

// File: rtl/evt_xfer_ctrl.sv
module evt_xfer_ctrl #(
  parameter int unsigned NCH = 8,
  parameter int unsigned AW  = 24,
  parameter int unsigned DW  = 16,
  parameter int unsigned CW  = 8,
  localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] trig_i,
  input  logic           cfg_we_i,
  input  logic [CHW-1:0] cfg_ch_i,
  input  logic [1:0]     cfg_sel_i,
  input  logic [AW-1:0]  cfg_wdata_i,
  output logic           bus_req_o,
  input  logic           bus_gnt_i,
  output logic           bus_we_o,
  output logic           bus_size_o,
  output logic [AW-1:0]  bus_addr_o,
  output logic [DW-1:0]  bus_wdata_o,
  input  logic [DW-1:0]  bus_rdata_i,
  output logic           done_o,
  output logic [CHW-1:0] done_ch_o,
  output logic [NCH-1:0] irq_o
);
  logic [NCH-1:0] pend_w, word_w, upd_w;
  logic [AW-1:0]  src_w [NCH];
  logic [AW-1:0]  dst_w [NCH];
  logic           any_w, wr_w;
  logic [CHW-1:0] sel_w, cur_w;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign upd_w[c] = wr_w && (cur_w == CHW'(c));
    evx_chan #(.AW(AW), .CW(CW)) u_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .trig_i      (trig_i[c]),
      .cfg_we_i    (cfg_we_i && (cfg_ch_i == CHW'(c))),
      .cfg_sel_i   (cfg_sel_i),
      .cfg_wdata_i (cfg_wdata_i),
      .upd_i       (upd_w[c]),
      .pend_o      (pend_w[c]),
      .word_o      (word_w[c]),
      .src_o       (src_w[c]),
      .dst_o       (dst_w[c]),
      .irq_o       (irq_o[c])
    );
  end

  evx_prio #(.N(NCH)) u_prio (
    .req_i (pend_w),
    .any_o (any_w),
    .idx_o (sel_w)
  );

  evx_seq #(.NCH(NCH), .AW(AW), .DW(DW)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .any_i      (any_w),
    .sel_i      (sel_w),
    .src_sel_i  (src_w[sel_w]),
    .word_sel_i (word_w[sel_w]),
    .dst_cur_i  (dst_w[cur_w]),
    .word_cur_i (word_w[cur_w]),
    .gnt_i      (bus_gnt_i),
    .rdata_i    (bus_rdata_i),
    .req_o      (bus_req_o),
    .we_o       (bus_we_o),
    .size_o     (bus_size_o),
    .addr_o     (bus_addr_o),
    .wdata_o    (bus_wdata_o),
    .wr_o       (wr_w),
    .cur_o      (cur_w)
  );

  assign done_o    = wr_w;
  assign done_ch_o = cur_w;
endmodule

// File: rtl/evx_chk.sv
module evx_chk #(
  parameter int unsigned NCH = 8,
  parameter int unsigned AW  = 24,
  parameter int unsigned DW  = 16
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [NCH-1:0] trig_i,
  input logic           bus_req_o,
  input logic           bus_gnt_i,
  input logic           bus_we_o,
  input logic           bus_size_o,
  input logic [AW-1:0]  bus_addr_o,
  input logic [DW-1:0]  bus_wdata_o,
  input logic           done_o,
  input logic [NCH-1:0] irq_o
);
  // R9
  write_follows_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_we_o && bus_gnt_i) |=> (bus_req_o && bus_we_o));

  // R9
  write_needs_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_o |-> $past(bus_req_o && !bus_we_o && bus_gnt_i));

  // R8
  done_on_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (bus_req_o && bus_we_o && $past(bus_gnt_i)));

  // R7
  single_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_o |=> !bus_we_o);

  // R6
  irq_from_trig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|irq_o) |-> ((irq_o & ~$past(trig_i)) == '0));

  // R3
  byte_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_o && !bus_size_o) |-> (bus_wdata_o[DW-1:8] == '0));

  // R1
  addr_known_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> !$isunknown(bus_addr_o));
endmodule

bind evt_xfer_ctrl evx_chk #(.NCH(NCH), .AW(AW), .DW(DW)) u_evx_chk (.*);

// File: tb/tb_evt_xfer_ctrl.sv
`timescale 1ns/1ps
module tb_evt_xfer_ctrl;
  localparam int NCH = 8, AW = 24, DW = 16, CHW = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] trig = '0;
  logic           cfg_we = 1'b0;
  logic [CHW-1:0] cfg_ch = '0;
  logic [1:0]     cfg_sel = '0;
  logic [AW-1:0]  cfg_wd = '0;
  logic           gnt = 1'b1;
  logic           req, we, size, done;
  logic [AW-1:0]  addr;
  logic [DW-1:0]  wdata, rdata;
  logic [CHW-1:0] done_ch;
  logic [NCH-1:0] irq;

  always #2.5 clk = ~clk;

  function automatic logic [15:0] memfn(input logic [23:0] a);
    return {a[7:0], a[15:8]} ^ 16'h3C5A;
  endfunction

  assign rdata = memfn(addr);

  evt_xfer_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig),
    .cfg_we_i(cfg_we), .cfg_ch_i(cfg_ch), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wd),
    .bus_req_o(req), .bus_gnt_i(gnt), .bus_we_o(we), .bus_size_o(size),
    .bus_addr_o(addr), .bus_wdata_o(wdata), .bus_rdata_i(rdata),
    .done_o(done), .done_ch_o(done_ch), .irq_o(irq)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_mode[NCH], m_word[NCH], m_cont[NCH], m_cnt[NCH], m_src[NCH], m_dst[NCH];
  bit m_pend[NCH], m_irq[NCH];
  int m_phase, m_cur, m_data;

  function automatic int m_low();
    for (int c = 0; c < NCH; c++) if (m_pend[c]) return c;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        m_mode[c] = 0; m_word[c] = 0; m_cont[c] = 0; m_cnt[c] = 0;
        m_src[c] = 0; m_dst[c] = 0; m_pend[c] = 0; m_irq[c] = 0;
      end
      m_phase = 0; m_cur = 0; m_data = 0;
    end else begin
      bit setv[NCH];
      int upd;
      upd = m_phase ? m_cur : -1;
      for (int c = 0; c < NCH; c++) begin
        int ce;
        bit lv;
        ce = (upd == c && !m_cont[c]) ? m_cnt[c] - 1 : m_cnt[c];
        lv = (m_mode[c] != 0) && (m_cont[c] != 0 || ce != 0);
        m_irq[c] = trig[c] && !lv;
        setv[c]  = trig[c] && lv;
      end
      if (m_phase == 0) begin
        if (m_low() >= 0 && gnt) begin
          m_cur = m_low();
          m_data = m_word[m_cur] ? int'(memfn(m_src[m_cur])) : int'(memfn(m_src[m_cur]) & 16'hFF);
          m_phase = 1;
        end
      end else begin
        int st;
        st = m_word[m_cur] ? 2 : 1;
        if (m_mode[m_cur] == 1) m_src[m_cur] = (m_src[m_cur] + st) & 24'hFFFFFF;
        if (m_mode[m_cur] == 2) m_dst[m_cur] = (m_dst[m_cur] + st) & 24'hFFFFFF;
        if (!m_cont[m_cur]) m_cnt[m_cur] = m_cnt[m_cur] - 1;
        m_pend[m_cur] = 0;
        m_phase = 0;
      end
      for (int c = 0; c < NCH; c++) if (setv[c]) m_pend[c] = 1;
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: begin
            m_mode[cfg_ch] = int'(cfg_wd[1:0]);
            m_word[cfg_ch] = int'(cfg_wd[2]);
            m_cont[cfg_ch] = int'(cfg_wd[3]);
          end
          2'd1: m_cnt[cfg_ch] = int'(cfg_wd[7:0]);
          2'd2: m_src[cfg_ch] = int'(cfg_wd);
          default: m_dst[cfg_ch] = int'(cfg_wd);
        endcase
      end
    end
  end

  // per-cycle compare against the model, plus logs for directed checks
  int dlog_ch[$], dlog_addr[$], dlog_data[$];
  int irq_cnt[NCH];

  always @(negedge clk) begin
    if (rst_n) begin
      int lo;
      bit ereq;
      lo = m_low();
      ereq = (m_phase == 1) || (lo >= 0);
      chk(req == ereq, "R9 bus_req", req, ereq);
      chk(done == (m_phase == 1), "R8 done", done, m_phase);
      if (ereq) begin
        chk(we == (m_phase == 1), "R2 bus_we", we, m_phase);
        if (m_phase == 1) begin
          chk(addr == m_dst[m_cur][23:0], "R2 write addr", addr, m_dst[m_cur]);
          chk(size == m_word[m_cur][0], "R3 size", size, m_word[m_cur]);
          chk(wdata == m_data[15:0], "R2 write data", wdata, m_data);
          chk(done_ch == m_cur[2:0], "R8 done_ch", done_ch, m_cur);
        end else begin
          chk(addr == m_src[lo][23:0], "R7 read addr", addr, m_src[lo]);
          chk(size == m_word[lo][0], "R3 size", size, m_word[lo]);
        end
      end
      for (int c = 0; c < NCH; c++) begin
        chk(irq[c] == m_irq[c], "R6 irq", irq[c], m_irq[c]);
        if (irq[c]) irq_cnt[c]++;
      end
      if (done) begin
        dlog_ch.push_back(int'(done_ch));
        dlog_addr.push_back(int'(addr));
        dlog_data.push_back(int'(wdata));
      end
    end
  end

  task automatic cfg(input int ch, input int sel, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = CHW'(ch); cfg_sel = 2'(sel); cfg_wd = AW'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic fire(input logic [NCH-1:0] m);
    @(negedge clk);
    trig = m;
    @(negedge clk);
    trig = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_logs();
    dlog_ch.delete(); dlog_addr.delete(); dlog_data.delete();
    for (int c = 0; c < NCH; c++) irq_cnt[c] = 0;
  endtask

  task automatic run_tests();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(req == 1'b0, "R1 req after reset", req, 0);
    chk(done == 1'b0, "R1 done after reset", done, 0);
    chk(irq == '0, "R1 irq after reset", irq, 0);

    // ch2: word, advance source, count 3
    clear_logs();
    cfg(2, 0, 'h5); cfg(2, 1, 3); cfg(2, 2, 'h100); cfg(2, 3, 'h200);
    fire(8'h04); idle(4);
    fire(8'h04); idle(4);
    fire(8'h04); idle(4);
    chk(dlog_ch.size() == 3, "R2 transfer count", dlog_ch.size(), 3);
    if (dlog_ch.size() == 3) begin
      chk(dlog_addr[0] == 'h200, "R4 fixed dst", dlog_addr[0], 'h200);
      chk(dlog_data[0] == int'(memfn('h100)), "R2 data", dlog_data[0], memfn('h100));
      chk(dlog_data[1] == int'(memfn('h102)), "R3 word step", dlog_data[1], memfn('h102));
      chk(dlog_data[2] == int'(memfn('h104)), "R4 src advance", dlog_data[2], memfn('h104));
    end
    // R5 / R6: counter drained, next trigger is forwarded
    fire(8'h04); idle(4);
    chk(dlog_ch.size() == 3, "R5 no move at zero", dlog_ch.size(), 3);
    chk(irq_cnt[2] == 1, "R6 fallback irq", irq_cnt[2], 1);

    // ch5: byte, advance destination, continuous at count 0
    clear_logs();
    cfg(5, 0, 'hA); cfg(5, 1, 0); cfg(5, 2, 'h300); cfg(5, 3, 'h400);
    for (int k = 0; k < 3; k++) begin fire(8'h20); idle(3); end
    chk(dlog_ch.size() == 3, "R5 continuous moves", dlog_ch.size(), 3);
    if (dlog_ch.size() == 3) begin
      chk(dlog_addr[2] == 'h402, "R3 byte step", dlog_addr[2], 'h402);
      chk(dlog_data[0] == int'(memfn('h300) & 16'hFF), "R3 byte data", dlog_data[0], memfn('h300) & 16'hFF);
    end
    chk(irq_cnt[5] == 0, "R5 no irq continuous", irq_cnt[5], 0);

    // ch1: word, advance neither
    clear_logs();
    cfg(1, 0, 'h7); cfg(1, 1, 2); cfg(1, 2, 'h500); cfg(1, 3, 'h600);
    fire(8'h02); idle(3); fire(8'h02); idle(3);
    chk(dlog_ch.size() == 2, "R4 fixed moves", dlog_ch.size(), 2);
    if (dlog_ch.size() == 2) begin
      chk(dlog_addr[1] == 'h600, "R4 dst held", dlog_addr[1], 'h600);
      chk(dlog_data[1] == int'(memfn('h500)), "R4 src held", dlog_data[1], memfn('h500));
    end

    // ch0 off
    clear_logs();
    fire(8'h01); idle(3);
    chk(irq_cnt[0] == 1, "R6 off channel irq", irq_cnt[0], 1);
    chk(dlog_ch.size() == 0, "R6 off no move", dlog_ch.size(), 0);

    // contention with grant withheld
    clear_logs();
    cfg(1, 1, 4); cfg(2, 1, 5);
    gnt = 1'b0;
    fire(8'h26); fire(8'h04); fire(8'h04); idle(3);
    chk(dlog_ch.size() == 0, "R9 wait for grant", dlog_ch.size(), 0);
    chk(req == 1'b1, "R9 request held", req, 1);
    gnt = 1'b1;
    idle(10);
    chk(dlog_ch.size() == 3, "R10 merged triggers", dlog_ch.size(), 3);
    if (dlog_ch.size() == 3) begin
      chk(dlog_ch[0] == 1, "R7 first", dlog_ch[0], 1);
      chk(dlog_ch[1] == 2, "R7 second", dlog_ch[1], 2);
      chk(dlog_ch[2] == 5, "R7 third", dlog_ch[2], 5);
      chk(dlog_addr[1] == 'h200, "R8 ch2 dst", dlog_addr[1], 'h200);
    end
    idle(2);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R2 watchdog act=timeout exp=completion");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule